// File: doc/BRIEF.md
# Accumulator ALU Flag Generator

This block computes the result and the next condition-flag byte for the arithmetic, logical, bit-test and shift operations of an 8-bit accumulator processor. Each operation is presented as a 4-bit operation code together with the accumulator, a 16-bit register-pair left operand, a 16-bit right operand, an incoming carry and a 3-bit selector. The result leaves the block combinationally in the same cycle. The flag byte is held in a register inside the block and is loaded at the next rising clock edge whenever the write enable is high.

Every operation class has its own write mask. Flag positions inside the mask take the newly computed value. Positions outside it keep the value they held before. The merged byte is therefore (computed AND mask) OR (previous AND NOT mask). 8-bit operations use the low byte of the right operand and ignore its high byte. Increment, decrement, bit test and all rotates and shifts act on the accumulator. The 16-bit operations act on the register-pair operand and the full right operand. Instruction decode, the register file and sequencing live outside this block.

Top module: `alu_flag_unit`

## Requirements
- R1: The flag byte holds carry at bit 0, subtract at bit 1, parity/overflow at bit 2, a result bit-3 copy at bit 3, half-carry at bit 4, a result bit-5 copy at bit 5, zero at bit 6 and sign at bit 7. It is 0x00 after reset, is loaded on a rising edge when `flag_we` is 1, and does not change when `flag_we` is 0.
- R2: Add (op 0) and add-with-carry (op 1, which adds `carry_in`) return the low byte of acc+operand[7:0](+cin) and update all flags. Carry is bit 8 of the sum. Half-carry is the carry out of bit 3. Overflow is set when both inputs have the same sign and the result sign differs. Subtract is 0. Bits 3 and 5 are copied from the result.
- R3: Subtract (op 2) and subtract-with-carry (op 3, which also subtracts `carry_in`) update all flags. Carry is the borrow out of bit 8. Half-carry is the borrow out of bit 4. Overflow is set when the inputs differ in sign and the result sign differs from the accumulator. Subtract is 1.
- R4: Compare (op 4) sets the flags of acc-operand[7:0] as in R3, but bits 3 and 5 are copied from the operand. The result output equals the accumulator.
- R5: AND (op 5), XOR (op 6) and OR (op 7) clear carry and subtract. Parity/overflow is set for an even number of ones in the result. Half-carry is set for AND only. Zero, sign and bits 3 and 5 follow the result.
- R6: Increment (op 8) and decrement (op 9) of the accumulator use mask 0xFE, so carry is kept. Overflow and half-carry are those of adding or subtracting 1. Subtract is set only for decrement.
- R7: 16-bit add (op 10) uses mask 0x3B, so sign, zero and parity/overflow are kept. Carry is bit 16. Half-carry is the carry out of bit 11. Bits 3 and 5 are result bits 11 and 13. Subtract is 0.
- R8: 16-bit add-with-carry (op 11) and subtract-with-carry (op 12) update all flags. Zero covers all 16 result bits. Sign is bit 15. Overflow is judged on bit 15. Carry is bit 16 or the borrow. Half-carry is the carry or borrow out of bit 11.
- R9: Bit test (op 13) of acc bit `sel` uses mask 0xFE, sets half-carry and clears subtract. A 0 bit sets zero and parity/overflow and clears sign, bit 3 and bit 5. A 1 bit clears zero and parity/overflow and sets sign, bit 3 or bit 5 only for index 7, 3 or 5 respectively. The result equals the accumulator.
- R10: Accumulator rotate (op 14) uses mask 0x3B. Carry gets the bit shifted out, subtract and half-carry are cleared, and bits 3 and 5 come from the new value. `sel` picks the kind: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left with 0 fill, 5 arithmetic shift right, 6 shift left with 1 fill, 7 logical shift right.
- R11: General rotate/shift (op 15) uses the kinds of R10 and updates all flags. Carry is the bit shifted out, subtract and half-carry are 0, parity/overflow is even parity, and zero, sign and bits 3 and 5 follow the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Load the merged flag byte at the next rising edge |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator |
| pair_lhs | input | 16 | Left operand of 16-bit operations |
| operand | input | 16 | Right operand; the low byte is used by 8-bit operations |
| carry_in | input | 1 | Carry for the with-carry forms and rotates through carry |
| sel | input | 3 | Bit index for bit test, or rotate/shift kind |
| result | output | 16 | Operation result, zero-extended for 8-bit operations |
| flags | output | 8 | Registered flag byte |

## Verification
The result is combinational, so it is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples `result` 1 ns later. The flag byte passes through one register, so it is due at the first rising edge after the stimulus. The bench samples `flags` 1 ns after that edge and compares it with a flag model that carries the previous byte forward, so every bit that a mask keeps is checked against a value built up from earlier vectors.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int MID_W  = WORD_W - NIB_W;
    localparam int FLAG_W = 8;
    localparam int SEL_W  = 3;

    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_PV = 2;
    localparam int FB_X3 = 3;
    localparam int FB_H  = 4;
    localparam int FB_X5 = 5;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    localparam logic [FLAG_W-1:0] MASK_ALL   = 8'hFF;
    localparam logic [FLAG_W-1:0] MASK_KEEPC = 8'hFE;
    localparam logic [FLAG_W-1:0] MASK_LITE  = 8'h3B;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_CMP   = 4'd4,
        OP_AND   = 4'd5,
        OP_XOR   = 4'd6,
        OP_OR    = 4'd7,
        OP_INC   = 4'd8,
        OP_DEC   = 4'd9,
        OP_ADDW  = 4'd10,
        OP_ADCW  = 4'd11,
        OP_SBCW  = 4'd12,
        OP_TEST  = 4'd13,
        OP_ROTA  = 4'd14,
        OP_SHIFT = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } fu_state_t;

    function automatic logic [FLAG_W-1:0] pack_flags(
        input logic s, input logic z, input logic x5, input logic h,
        input logic x3, input logic pv, input logic n, input logic c);
        return {s, z, x5, h, x3, pv, n, c};
    endfunction

    function automatic logic even_par(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/fg_add_sub8.sv
module fg_add_sub8
    import flag_unit_pkg::*;
(
    input  logic [BYTE_W-1:0] lhs,
    input  logic [BYTE_W-1:0] rhs,
    input  logic              cin,
    input  logic              sub,
    input  logic              x_from_rhs,
    output logic [BYTE_W-1:0] res,
    output logic [FLAG_W-1:0] flg
);
    localparam int MSB = BYTE_W - 1;

    logic [BYTE_W:0] full;
    logic [NIB_W:0]  nib;
    logic            ovf;
    logic            x3_bit;
    logic            x5_bit;

    always_comb begin
        if (sub) begin
            full = {1'b0, lhs} - {1'b0, rhs} - (BYTE_W+1)'(cin);
            nib  = {1'b0, lhs[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]} - (NIB_W+1)'(cin);
            ovf  = (lhs[MSB] != rhs[MSB]) && (full[MSB] != lhs[MSB]);
        end else begin
            full = {1'b0, lhs} + {1'b0, rhs} + (BYTE_W+1)'(cin);
            nib  = {1'b0, lhs[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]} + (NIB_W+1)'(cin);
            ovf  = (lhs[MSB] == rhs[MSB]) && (full[MSB] != lhs[MSB]);
        end
        res    = full[BYTE_W-1:0];
        x3_bit = x_from_rhs ? rhs[3] : res[3];
        x5_bit = x_from_rhs ? rhs[5] : res[5];
        flg    = pack_flags(res[MSB], res == '0, x5_bit, nib[NIB_W], x3_bit,
                            ovf, sub, full[BYTE_W]);
    end

endmodule

// File: rtl/fg_add_sub16.sv
module fg_add_sub16
    import flag_unit_pkg::*;
(
    input  logic [WORD_W-1:0] lhs,
    input  logic [WORD_W-1:0] rhs,
    input  logic              cin,
    input  logic              sub,
    output logic [WORD_W-1:0] res,
    output logic [FLAG_W-1:0] flg
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W:0] full;
    logic [MID_W:0]  mid;
    logic            ovf;

    always_comb begin
        if (sub) begin
            full = {1'b0, lhs} - {1'b0, rhs} - (WORD_W+1)'(cin);
            mid  = {1'b0, lhs[MID_W-1:0]} - {1'b0, rhs[MID_W-1:0]} - (MID_W+1)'(cin);
            ovf  = (lhs[MSB] != rhs[MSB]) && (full[MSB] != lhs[MSB]);
        end else begin
            full = {1'b0, lhs} + {1'b0, rhs} + (WORD_W+1)'(cin);
            mid  = {1'b0, lhs[MID_W-1:0]} + {1'b0, rhs[MID_W-1:0]} + (MID_W+1)'(cin);
            ovf  = (lhs[MSB] == rhs[MSB]) && (full[MSB] != lhs[MSB]);
        end
        res = full[WORD_W-1:0];
        flg = pack_flags(res[MSB], res == '0, res[BYTE_W+5], mid[MID_W],
                         res[BYTE_W+3], ovf, sub, full[WORD_W]);
    end

endmodule

// File: rtl/fg_logic_test.sv
module fg_logic_test
    import flag_unit_pkg::*;
(
    input  logic [BYTE_W-1:0] lhs,
    input  logic [BYTE_W-1:0] rhs,
    input  logic [1:0]        fn,
    input  logic [SEL_W-1:0]  idx,
    output logic [BYTE_W-1:0] lres,
    output logic [FLAG_W-1:0] lflg,
    output logic [FLAG_W-1:0] tflg
);
    localparam int MSB = BYTE_W - 1;

    logic is_and;
    logic tbit;

    always_comb begin
        is_and = 1'b0;
        unique case (fn)
            2'd0: begin lres = lhs & rhs; is_and = 1'b1; end
            2'd1: lres = lhs ^ rhs;
            default: lres = lhs | rhs;
        endcase
        lflg = pack_flags(lres[MSB], lres == '0, lres[5], is_and, lres[3],
                          even_par(lres), 1'b0, 1'b0);

        tbit = lhs[idx];
        tflg = pack_flags(tbit && (idx == 3'd7), !tbit, tbit && (idx == 3'd5), 1'b1,
                          tbit && (idx == 3'd3), !tbit, 1'b0, 1'b0);
    end

endmodule

// File: rtl/fg_shift8.sv
module fg_shift8
    import flag_unit_pkg::*;
(
    input  logic [BYTE_W-1:0] val,
    input  logic              cin,
    input  logic [SEL_W-1:0]  kind,
    output logic [BYTE_W-1:0] res,
    output logic [FLAG_W-1:0] flg
);
    localparam int MSB = BYTE_W - 1;

    logic go_right;
    logic fill;
    logic out_bit;

    always_comb begin
        go_right = kind[0];
        unique case (kind[2:1])
            2'd0:    fill = go_right ? val[0] : val[MSB];
            2'd1:    fill = cin;
            2'd2:    fill = go_right ? val[MSB] : 1'b0;
            default: fill = !go_right;
        endcase
        if (go_right) begin
            res     = {fill, val[MSB:1]};
            out_bit = val[0];
        end else begin
            res     = {val[MSB-1:0], fill};
            out_bit = val[MSB];
        end
        flg = pack_flags(res[MSB], res == '0, res[5], 1'b0, res[3],
                         even_par(res), 1'b0, out_bit);
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import flag_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [3:0]        op,
    input  logic [BYTE_W-1:0] acc,
    input  logic [WORD_W-1:0] pair_lhs,
    input  logic [WORD_W-1:0] operand,
    input  logic              carry_in,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    localparam int N_ADDER = 2;
    localparam int ADD_MAIN = 0;
    localparam int ADD_STEP = 1;

    alu_op_e   opc;
    fu_state_t state_d, state_q;

    logic [BYTE_W-1:0] a8_rhs [N_ADDER];
    logic [BYTE_W-1:0] a8_res [N_ADDER];
    logic [FLAG_W-1:0] a8_flg [N_ADDER];
    logic              a8_cin [N_ADDER];
    logic              a8_sub [N_ADDER];
    logic              a8_xr  [N_ADDER];

    logic [WORD_W-1:0] w_res;
    logic [FLAG_W-1:0] w_flg;
    logic              w_cin;
    logic [1:0]        l_fn;
    logic [BYTE_W-1:0] l_res;
    logic [FLAG_W-1:0] l_flg;
    logic [FLAG_W-1:0] t_flg;
    logic [BYTE_W-1:0] s_res;
    logic [FLAG_W-1:0] s_flg;

    logic [WORD_W-1:0] res_w;
    logic [FLAG_W-1:0] calc_flg;
    logic [FLAG_W-1:0] wmask;

    assign opc = alu_op_e'(op);

    // main 8-bit adder/subtractor
    assign a8_rhs[ADD_MAIN] = operand[BYTE_W-1:0];
    assign a8_cin[ADD_MAIN] = carry_in && (opc == OP_ADC || opc == OP_SBC);
    assign a8_sub[ADD_MAIN] = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_CMP);
    assign a8_xr[ADD_MAIN]  = (opc == OP_CMP);

    // step-by-one adder for increment/decrement
    assign a8_rhs[ADD_STEP] = BYTE_W'(1);
    assign a8_cin[ADD_STEP] = 1'b0;
    assign a8_sub[ADD_STEP] = (opc == OP_DEC);
    assign a8_xr[ADD_STEP]  = 1'b0;

    for (genvar g = 0; g < N_ADDER; g++) begin : g_add8
        fg_add_sub8 u_add8 (
            .lhs        (acc),
            .rhs        (a8_rhs[g]),
            .cin        (a8_cin[g]),
            .sub        (a8_sub[g]),
            .x_from_rhs (a8_xr[g]),
            .res        (a8_res[g]),
            .flg        (a8_flg[g])
        );
    end

    assign w_cin = carry_in && (opc == OP_ADCW || opc == OP_SBCW);

    fg_add_sub16 u_add16 (
        .lhs (pair_lhs),
        .rhs (operand),
        .cin (w_cin),
        .sub (opc == OP_SBCW),
        .res (w_res),
        .flg (w_flg)
    );

    assign l_fn = (opc == OP_AND) ? 2'd0 : (opc == OP_XOR) ? 2'd1 : 2'd2;

    fg_logic_test u_logic (
        .lhs  (acc),
        .rhs  (operand[BYTE_W-1:0]),
        .fn   (l_fn),
        .idx  (sel),
        .lres (l_res),
        .lflg (l_flg),
        .tflg (t_flg)
    );

    fg_shift8 u_shift (
        .val  (acc),
        .cin  (carry_in),
        .kind (sel),
        .res  (s_res),
        .flg  (s_flg)
    );

    always_comb begin
        res_w    = '0;
        calc_flg = '0;
        wmask    = MASK_ALL;
        unique case (opc)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_w    = WORD_W'(a8_res[ADD_MAIN]);
                calc_flg = a8_flg[ADD_MAIN];
            end
            OP_CMP: begin
                res_w    = WORD_W'(acc);
                calc_flg = a8_flg[ADD_MAIN];
            end
            OP_AND, OP_XOR, OP_OR: begin
                res_w    = WORD_W'(l_res);
                calc_flg = l_flg;
            end
            OP_INC, OP_DEC: begin
                res_w    = WORD_W'(a8_res[ADD_STEP]);
                calc_flg = a8_flg[ADD_STEP];
                wmask    = MASK_KEEPC;
            end
            OP_ADDW: begin
                res_w    = w_res;
                calc_flg = w_flg;
                wmask    = MASK_LITE;
            end
            OP_ADCW, OP_SBCW: begin
                res_w    = w_res;
                calc_flg = w_flg;
            end
            OP_TEST: begin
                res_w    = WORD_W'(acc);
                calc_flg = t_flg;
                wmask    = MASK_KEEPC;
            end
            OP_ROTA: begin
                res_w    = WORD_W'(s_res);
                calc_flg = s_flg;
                wmask    = MASK_LITE;
            end
            default: begin
                res_w    = WORD_W'(s_res);
                calc_flg = s_flg;
            end
        endcase

        state_d = state_q;
        if (flag_we) begin
            state_d.flags = (calc_flg & wmask) | (state_q.flags & ~wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = res_w;
    assign flags  = state_q.flags;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags)); // R1

    AST_ADD_NOT_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && (opc == OP_ADD || opc == OP_ADC) |=> !flags[FB_N]); // R2

    AST_SUB_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && (opc inside {OP_SUB, OP_SBC, OP_CMP}) |=> flags[FB_N]); // R3

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        opc == OP_CMP |-> result[BYTE_W-1:0] == acc); // R4

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && (opc inside {OP_AND, OP_XOR, OP_OR}) |=> flags[FB_N:FB_C] == 2'b00); // R5

    AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && (opc == OP_INC || opc == OP_DEC) |=> flags[FB_C] == $past(flags[FB_C])); // R6

    AST_WADD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && opc == OP_ADDW |=> flags[FB_S:FB_Z] == $past(flags[FB_S:FB_Z])
                                   && flags[FB_PV] == $past(flags[FB_PV])); // R7

    AST_TEST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && opc == OP_TEST |=> flags[FB_H] && !flags[FB_N]
                                   && flags[FB_C] == $past(flags[FB_C])); // R9

    AST_TEST_ZERO_PV: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && opc == OP_TEST |=> flags[FB_Z] == flags[FB_PV]); // R9

    AST_ROTA_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && opc == OP_ROTA |=> flags[FB_S:FB_Z] == $past(flags[FB_S:FB_Z])
                                   && !flags[FB_H] && !flags[FB_N]); // R10

    AST_SHIFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we && opc == OP_SHIFT |=> !flags[FB_H] && !flags[FB_N]); // R11

endmodule

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_we = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  acc = '0;
    logic [15:0] pair_lhs = '0;
    logic [15:0] operand = '0;
    logic        carry_in = 1'b0;
    logic [2:0]  sel = '0;
    logic [15:0] result;
    logic [7:0]  flags;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] ref_flags = '0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_we  (flag_we),
        .op       (op),
        .acc      (acc),
        .pair_lhs (pair_lhs),
        .operand  (operand),
        .carry_in (carry_in),
        .sel      (sel),
        .result   (result),
        .flags    (flags)
    );

    function automatic string tag(input int o);
        case (o)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4:       return "R4";
            5, 6, 7: return "R5";
            8, 9:    return "R6";
            10:      return "R7";
            11, 12:  return "R8";
            13:      return "R9";
            14:      return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int par_even(input int v);
        int cnt = 0;
        for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
        return (cnt % 2 == 0) ? 1 : 0;
    endfunction

    function automatic logic [7:0] fpack(input int s, input int z, input int x5, input int h,
                                         input int x3, input int pv, input int n, input int c);
        return 8'((s << 7) | (z << 6) | (x5 << 5) | (h << 4) | (x3 << 3) | (pv << 2) | (n << 1) | c);
    endfunction

    function automatic void model(input int o, input int a, input int p, input int b,
                                  input int c, input int idx, input logic [7:0] prev,
                                  output int r, output logic [7:0] nf);
        int s, hs, v, cy, mk, cc, b8, t, outb, fill;
        logic [7:0] cf;
        b8 = b & 255;
        mk = 255;
        r  = a;
        cf = '0;
        case (o)
            0, 1: begin
                cc = (o == 1) ? c : 0;
                s  = a + b8 + cc;
                r  = s & 255;
                cy = (s > 255) ? 1 : 0;
                hs = (((a & 15) + (b8 & 15) + cc) > 15) ? 1 : 0;
                v  = (((a ^ r) & (b8 ^ r) & 128) != 0) ? 1 : 0;
                cf = fpack((r >> 7) & 1, r == 0, (r >> 5) & 1, hs, (r >> 3) & 1, v, 0, cy);
            end
            2, 3, 4: begin
                cc = (o == 3) ? c : 0;
                s  = a - b8 - cc;
                r  = s & 255;
                cy = (s < 0) ? 1 : 0;
                hs = (((a & 15) - (b8 & 15) - cc) < 0) ? 1 : 0;
                v  = (((a ^ b8) & (a ^ r) & 128) != 0) ? 1 : 0;
                t  = (o == 4) ? b8 : r;
                cf = fpack((r >> 7) & 1, r == 0, (t >> 5) & 1, hs, (t >> 3) & 1, v, 1, cy);
                if (o == 4) r = a;
            end
            5, 6, 7: begin
                r  = (o == 5) ? (a & b8) : (o == 6) ? (a ^ b8) : (a | b8);
                cf = fpack((r >> 7) & 1, r == 0, (r >> 5) & 1, (o == 5), (r >> 3) & 1,
                           par_even(r), 0, 0);
            end
            8, 9: begin
                r  = (o == 8) ? ((a + 1) & 255) : ((a - 1) & 255);
                v  = (o == 8) ? (a == 127) : (a == 128);
                hs = (o == 8) ? ((a & 15) == 15) : ((a & 15) == 0);
                cf = fpack((r >> 7) & 1, r == 0, (r >> 5) & 1, hs, (r >> 3) & 1, v, (o == 9), 0);
                mk = 254;
            end
            10, 11, 12: begin
                cc = (o == 10) ? 0 : c;
                if (o == 12) begin
                    s  = p - b - cc;
                    cy = (s < 0) ? 1 : 0;
                    hs = (((p & 4095) - (b & 4095) - cc) < 0) ? 1 : 0;
                    r  = s & 65535;
                    v  = (((p ^ b) & (p ^ r) & 32768) != 0) ? 1 : 0;
                end else begin
                    s  = p + b + cc;
                    cy = (s > 65535) ? 1 : 0;
                    hs = (((p & 4095) + (b & 4095) + cc) > 4095) ? 1 : 0;
                    r  = s & 65535;
                    v  = (((p ^ r) & (b ^ r) & 32768) != 0) ? 1 : 0;
                end
                cf = fpack((r >> 15) & 1, r == 0, (r >> 13) & 1, hs, (r >> 11) & 1, v, (o == 12), cy);
                mk = (o == 10) ? 59 : 255;
            end
            13: begin
                t  = (a >> idx) & 1;
                cf = fpack(t && idx == 7, !t, t && idx == 5, 1, t && idx == 3, !t, 0, 0);
                mk = 254;
            end
            default: begin
                case (idx / 2)
                    0:       fill = (idx % 2) ? (a & 1) : ((a >> 7) & 1);
                    1:       fill = c;
                    2:       fill = (idx % 2) ? ((a >> 7) & 1) : 0;
                    default: fill = (idx % 2) ? 0 : 1;
                endcase
                if (idx % 2) begin
                    outb = a & 1;
                    r    = (fill << 7) | (a >> 1);
                end else begin
                    outb = (a >> 7) & 1;
                    r    = ((a << 1) & 255) | fill;
                end
                cf = fpack((r >> 7) & 1, r == 0, (r >> 5) & 1, 0, (r >> 3) & 1, par_even(r), 0, outb);
                mk = (o == 14) ? 59 : 255;
            end
        endcase
        nf = (cf & 8'(mk)) | (prev & ~8'(mk));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input bit we, input int o, input int a, input int p,
                         input int b, input int c, input int idx);
        int         er;
        logic [7:0] ef;
        @(negedge clk);
        flag_we  = we;
        op       = 4'(o);
        acc      = 8'(a);
        pair_lhs = 16'(p);
        operand  = 16'(b);
        carry_in = c[0];
        sel      = 3'(idx);
        model(o, a, p, b, c, idx, ref_flags, er, ef);
        if (!we) ef = ref_flags;
        #1;
        check(tag(o), "result", int'(result), er);
        @(posedge clk);
        #1;
        check(we ? tag(o) : "R1", "flags", int'(flags), int'(ef));
        ref_flags = ef;
    endtask

    initial begin
        #12;
        check("R1", "reset flags", int'(flags), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2..R5: 8-bit arithmetic and logic, with junk in the operand high byte
        for (int o = 0; o < 8; o++)
            for (int a = 0; a < 256; a += 3)
                for (int k = 0; k < 16; k++)
                    for (int c = 0; c < 2; c++) begin
                        int b8;
                        case (k)
                            0:       b8 = 0;
                            1:       b8 = 128;
                            2:       b8 = 127;
                            3:       b8 = 1;
                            15:      b8 = 255;
                            default: b8 = (k * 37 + a * 5 + 11) & 255;
                        endcase
                        apply(1'b1, o, a, 0, b8 | ((((a + k) * 29) & 255) << 8), c, k & 7);
                    end

        // R6: increment and decrement over every accumulator value
        for (int o = 8; o < 10; o++)
            for (int a = 0; a < 256; a++)
                for (int c = 0; c < 2; c++)
                    apply(1'b1, o, a, 0, a * 7, c, 0);

        // R7, R8: 16-bit arithmetic, corner pairs first
        for (int o = 10; o < 13; o++)
            for (int i = 0; i < 1500; i++) begin
                int p, b;
                case (i)
                    0: begin p = 65535; b = 1;     end
                    1: begin p = 32768; b = 32768; end
                    2: begin p = 32767; b = 1;     end
                    3: begin p = 0;     b = 0;     end
                    4: begin p = 4095;  b = 1;     end
                    5: begin p = 32768; b = 1;     end
                    6: begin p = 0;     b = 1;     end
                    7: begin p = 65535; b = 65535; end
                    default: begin
                        p = (i * 40503 + 12345) & 65535;
                        b = (i * 9973 + 777) & 65535;
                    end
                endcase
                apply(1'b1, o, i & 255, p, b, (i / 2) % 2, 0);
            end

        // R9: bit test of every bit of every accumulator value
        for (int a = 0; a < 256; a++)
            for (int idx = 0; idx < 8; idx++)
                apply(1'b1, 13, a, 0, 0, a & 1, idx);

        // R10, R11: all rotate/shift kinds, both carry values
        for (int o = 14; o < 16; o++)
            for (int a = 0; a < 256; a++)
                for (int idx = 0; idx < 8; idx++)
                    for (int c = 0; c < 2; c++)
                        apply(1'b1, o, a, 0, 0, c, idx);

        // R1: flags hold while the write enable is low
        for (int i = 0; i < 32; i++)
            apply(1'b0, i % 16, (i * 73) & 255, (i * 4099) & 65535, (i * 251) & 65535, i % 2, i % 8);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule